// File: doc/BRIEF.md
# Triggered Three-Phase Current ADC Reader

This block is an SPI master for a 12-bit multi-input successive-approximation converter that samples three motor phase currents. When the drive logic signals that the low-side switches have settled, it pulses `sample_go` for one clock. The reader then runs a burst of four back-to-back SPI frames and presents the three phase results together.

The converter returns, in each frame, the result of the input chosen in the previous frame. Because of this, the first frame of a burst only primes the address, and the next three frames return phases A, B and C in that order. The serial clock runs at exactly half the system clock, so the system clock must stay below 40 MHz to keep SCK at or below 20 MHz.

The result interface is a plain valid strobe with no ready. `res_valid` is high for one cycle, and the consumer must take the three words in that cycle. The words then hold until the next burst completes, so a late reader still sees the last set. There is no back-pressure.

Top module: `adc3_burst_reader`

## Requirements
- R1: While `adc_cs_n` is low, `adc_sck` toggles on every system clock, giving half the clock rate. While `adc_cs_n` is high, `adc_sck` rests high.
- R2: Each frame holds `adc_cs_n` low for exactly 16 SCK periods. Each period starts with SCK going low and ends with SCK high.
- R3: The control word on `adc_mosi` is sent MSB first. It changes only when SCK falls. Bit 15 is 1, bit 14 is 0, bits 13:11 are the input address, and bits 10:0 are the fixed configuration bits `CTRL_TAIL`.
- R4: Within a burst, the four frames carry addresses `CH_A`, `CH_B`, `CH_C`, `CH_A`, in that order.
- R5: `adc_miso` is sampled MSB first on each rising SCK edge. Bits 11:0 of the received word are the result. Bits 15:12 (flag and input tag) are ignored.
- R6: A burst is four frames. The word received in frame 0 is discarded. Frames 1, 2 and 3 give `phase_a`, `phase_b` and `phase_c`.
- R7: Between two frames, `adc_cs_n` stays high for at least two system clocks (`GAP_CYCLES`+1).
- R8: All three results update in the same cycle, and `res_valid` is high for exactly that one cycle. With default parameters this is 139 clock edges after the edge that sampled `sample_go`.
- R9: A `sample_go` pulse that arrives while a burst is running, including its final cycle, is ignored. It adds no frame and no result.
- R10: After reset, `adc_cs_n` and `adc_sck` are 1, `adc_mosi` and `res_valid` are 0, and all three results are 0.
- R11: Between completions, `phase_a`, `phase_b` and `phase_c` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, below 40 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_go | input | 1 | One-cycle trigger that starts a burst |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sck | output | 1 | Serial clock, half the system clock |
| adc_mosi | output | 1 | Control word to the converter |
| adc_miso | input | 1 | Serial data from the converter |
| phase_a | output | 12 | Phase A result |
| phase_b | output | 12 | Phase B result |
| phase_c | output | 12 | Phase C result |
| res_valid | output | 1 | One-cycle strobe marking fresh results |

## Verification
The hardest case to reach is a trigger that lands on the very edge where the last frame is being captured. At that edge the block is still busy but about to go idle. The stimulus pulses `sample_go` once in mid-burst and once on exactly that final edge, and then expects no extra frame and no second strobe. It also fires a new trigger on the same cycle that the strobe is seen. This proves that the first cycle after completion is accepted. A converter model answers with the address from the previous frame and sets the tag bits nonzero, so the priming frame and the masking of bits 15:12 both show up in the results.

// File: rtl/adc3_pkg.sv
package adc3_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} eng_state_e;
  localparam int unsigned BURST_FRAMES = 4;
  typedef logic [1:0] frame_idx_t;
  localparam frame_idx_t LAST_FRAME = 2'd3;
endpackage

// File: rtl/adc3_spi_frame.sv
module adc3_spi_frame
  import adc3_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned GAP_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  miso,
  output logic                  cs_n,
  output logic                  sck,
  output logic                  mosi,
  output logic                  idle,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_word
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam int unsigned GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_CYCLES - 1);

  eng_state_e            state;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] rxreg;
  logic [CNT_W-1:0]      bitcnt;
  logic [GAP_W-1:0]      gapcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      cs_n   <= 1'b1;
      sck    <= 1'b1;
      mosi   <= 1'b0;
      shreg  <= '0;
      rxreg  <= '0;
      bitcnt <= '0;
      gapcnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            cs_n   <= 1'b0;
            sck    <= 1'b0;
            mosi   <= tx_word[FRAME_BITS-1];
            shreg  <= {tx_word[FRAME_BITS-2:0], 1'b0};
            bitcnt <= '0;
            state  <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (!sck) begin
            sck   <= 1'b1;
            rxreg <= {rxreg[FRAME_BITS-2:0], miso};
          end else if (bitcnt == LAST_BIT) begin
            cs_n   <= 1'b1;
            mosi   <= 1'b0;
            done   <= 1'b1;
            gapcnt <= '0;
            state  <= ENG_GAP;
          end else begin
            sck    <= 1'b0;
            mosi   <= shreg[FRAME_BITS-1];
            shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ENG_GAP: begin
          if (gapcnt == GAP_END) state <= ENG_IDLE;
          else                   gapcnt <= gapcnt + 1'b1;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign idle    = (state == ENG_IDLE);
  assign rx_word = rxreg;

  AST_SCK_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sck); // R1
  AST_SCK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> (sck != $past(sck))); // R1
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R7
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sck)) |-> $stable(mosi)); // R3
endmodule

// File: rtl/adc3_burst_seq.sv
module adc3_burst_seq
  import adc3_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned ADDR_W     = 3,
  parameter logic [ADDR_W-1:0] CH_A = 3'd0,
  parameter logic [ADDR_W-1:0] CH_B = 3'd1,
  parameter logic [ADDR_W-1:0] CH_C = 3'd2,
  parameter logic [FRAME_BITS-3-ADDR_W:0] CTRL_TAIL = 11'h110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trigger,
  input  logic                  eng_idle,
  input  logic                  eng_done,
  output logic                  start,
  output logic [FRAME_BITS-1:0] tx_word,
  output logic                  cap_valid,
  output frame_idx_t            cap_slot
);
  localparam logic [ADDR_W-1:0] ADDR_SEQ [BURST_FRAMES] = '{CH_A, CH_B, CH_C, CH_A};

  logic       busy;
  logic       pend;
  frame_idx_t fidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      fidx <= '0;
    end else if (!busy) begin
      if (trigger) begin
        busy <= 1'b1;
        pend <= 1'b1;
        fidx <= '0;
      end
    end else begin
      if (start) pend <= 1'b0;
      if (eng_done) begin
        if (fidx == LAST_FRAME) begin
          busy <= 1'b0;
        end else begin
          fidx <= fidx + 2'd1;
          pend <= 1'b1;
        end
      end
    end
  end

  assign start     = busy && pend && eng_idle;
  assign tx_word   = {2'b10, ADDR_SEQ[fidx], CTRL_TAIL};
  assign cap_valid = busy && eng_done;
  assign cap_slot  = fidx;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> eng_idle); // R6
  AST_TRIGGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trigger && !eng_done) |=> (busy && fidx == $past(fidx))); // R9
endmodule

// File: rtl/adc3_result_bank.sv
module adc3_result_bank
  import adc3_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned DATA_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_valid,
  input  frame_idx_t            cap_slot,
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic [DATA_W-1:0]     phase_a,
  output logic [DATA_W-1:0]     phase_b,
  output logic [DATA_W-1:0]     phase_c,
  output logic                  res_valid
);
  logic [DATA_W-1:0] stage [2];
  logic [DATA_W-1:0] sample;

  assign sample = rx_word[DATA_W-1:0];

  for (genvar s = 0; s < 2; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (cap_valid && cap_slot == frame_idx_t'(s + 1)) stage[s] <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_a   <= '0;
      phase_b   <= '0;
      phase_c   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (cap_valid && cap_slot == LAST_FRAME) begin
        phase_a   <= stage[0];
        phase_b   <= stage[1];
        phase_c   <= sample;
        res_valid <= 1'b1;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(phase_a) && $stable(phase_b) && $stable(phase_c))); // R11
endmodule

// File: rtl/adc3_burst_reader.sv
module adc3_burst_reader
  import adc3_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned GAP_CYCLES = 2,
  parameter logic [ADDR_W-1:0] CH_A = 3'd0,
  parameter logic [ADDR_W-1:0] CH_B = 3'd1,
  parameter logic [ADDR_W-1:0] CH_C = 3'd2,
  parameter logic [FRAME_BITS-3-ADDR_W:0] CTRL_TAIL = 11'h110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_go,
  output logic              adc_cs_n,
  output logic              adc_sck,
  output logic              adc_mosi,
  input  logic              adc_miso,
  output logic [DATA_W-1:0] phase_a,
  output logic [DATA_W-1:0] phase_b,
  output logic [DATA_W-1:0] phase_c,
  output logic              res_valid
);
  logic                  start;
  logic                  eng_idle;
  logic                  eng_done;
  logic [FRAME_BITS-1:0] tx_word;
  logic [FRAME_BITS-1:0] rx_word;
  logic                  cap_valid;
  frame_idx_t            cap_slot;

  adc3_burst_seq #(
    .FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W),
    .CH_A(CH_A), .CH_B(CH_B), .CH_C(CH_C), .CTRL_TAIL(CTRL_TAIL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trigger(sample_go),
    .eng_idle(eng_idle), .eng_done(eng_done),
    .start(start), .tx_word(tx_word),
    .cap_valid(cap_valid), .cap_slot(cap_slot)
  );

  adc3_spi_frame #(
    .FRAME_BITS(FRAME_BITS), .GAP_CYCLES(GAP_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .miso(adc_miso), .cs_n(adc_cs_n), .sck(adc_sck), .mosi(adc_mosi),
    .idle(eng_idle), .done(eng_done), .rx_word(rx_word)
  );

  adc3_result_bank #(
    .FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_slot(cap_slot),
    .rx_word(rx_word), .phase_a(phase_a), .phase_b(phase_b),
    .phase_c(phase_c), .res_valid(res_valid)
  );
endmodule

// File: tb/adc3_burst_reader_bench.sv
module adc3_burst_reader_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LAT = 4 * (2 * 16 + 2 + 1);
  localparam logic [10:0] TAIL = 11'h110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_go = 1'b0;
  logic adc_cs_n, adc_sck, adc_mosi;
  logic adc_miso = 1'b0;
  logic [11:0] phase_a, phase_b, phase_c;
  logic res_valid;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc3_burst_reader u_adc3_burst_reader (
    .clk(clk), .rst_n(rst_n), .sample_go(sample_go),
    .adc_cs_n(adc_cs_n), .adc_sck(adc_sck), .adc_mosi(adc_mosi),
    .adc_miso(adc_miso), .phase_a(phase_a), .phase_b(phase_b),
    .phase_c(phase_c), .res_valid(res_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Converter model: returns the word of the address latched in the previous frame
  logic [11:0] chan_val [8];
  int pipe_addr = 0;
  int bitn = 0;
  int frames_seen = 0;
  bit in_frame = 0;
  logic [15:0] resp;
  logic [15:0] mosi_sh;
  int exp_addr [4] = '{0, 1, 2, 0};

  always @(negedge adc_cs_n) begin
    bitn = 0;
    in_frame = 1;
  end

  always @(negedge adc_sck) begin
    #0.5;
    if (!adc_cs_n) begin
      if (bitn == 0) resp = {1'b1, 3'(pipe_addr), chan_val[pipe_addr]};  // R5 nonzero tag bits
      adc_miso = resp[15 - bitn];
    end
  end

  always @(posedge adc_sck) begin
    if (!adc_cs_n) begin
      mosi_sh = {mosi_sh[14:0], adc_mosi};
      bitn++;
    end
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      chk(bitn == 16, "R2 bits per frame", bitn, 16);
      chk(mosi_sh[15:14] == 2'b10 && mosi_sh[10:0] == TAIL, "R3 control word", mosi_sh, {2'b10, 3'(exp_addr[frames_seen % 4]), TAIL});
      chk(int'(mosi_sh[13:11]) == exp_addr[frames_seen % 4], "R4 address order", mosi_sh[13:11], exp_addr[frames_seen % 4]);
      pipe_addr = int'(mosi_sh[13:11]);
      frames_seen++;
    end
  end

  // Cycle reference model
  bit busy_m = 0;
  int cnt_m = 0;
  int bursts_m = 0;
  int valids_seen = 0;
  logic [11:0] snap_a, snap_b, snap_c;
  logic [11:0] pub_a = '0, pub_b = '0, pub_c = '0;
  logic prev_cs = 1'b1, prev_sck = 1'b1;
  int hi_run = 0;
  bit model_on = 0;

  always @(posedge clk) begin
    if (model_on && !busy_m && sample_go) begin
      busy_m = 1;
      cnt_m = 0;
      snap_a = chan_val[0];
      snap_b = chan_val[1];
      snap_c = chan_val[2];
      bursts_m++;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit exp_v;
      exp_v = 0;
      if (busy_m) begin
        cnt_m++;
        if (cnt_m == LAT) begin
          exp_v = 1;
          busy_m = 0;
          pub_a = snap_a; pub_b = snap_b; pub_c = snap_c;
        end
      end
      if (res_valid) valids_seen++;
      chk(res_valid == exp_v, "R8 strobe timing", res_valid, exp_v);
      chk({phase_a, phase_b, phase_c} == {pub_a, pub_b, pub_c},
          exp_v ? "R6 phase results" : "R11 results hold",
          {phase_a, phase_b, phase_c}, {pub_a, pub_b, pub_c});
      if (adc_cs_n) chk(adc_sck == 1'b1, "R1 sck rests high", adc_sck, 1);
      else if (!prev_cs) chk(adc_sck != prev_sck, "R1 sck half rate", adc_sck, ~prev_sck);
      if (!adc_cs_n && prev_cs) chk(hi_run >= 2, "R7 cs gap", hi_run, 2);
      hi_run = adc_cs_n ? hi_run + 1 : 0;
      prev_cs = adc_cs_n;
      prev_sck = adc_sck;
    end
  end

  task automatic run_burst(input logic [11:0] a, input logic [11:0] b, input logic [11:0] c,
                           input bit retrig, input bit now);
    int k;
    if (!now) @(negedge clk);
    chan_val[0] = a; chan_val[1] = b; chan_val[2] = c;
    sample_go = 1'b1;
    @(negedge clk);
    sample_go = 1'b0;
    k = 1;
    while (!res_valid && k < 400) begin
      @(negedge clk);
      k++;
      sample_go = retrig && (k == 50 || k == 139);  // R9 mid-burst and final-edge triggers
    end
    sample_go = 1'b0;
    chk(k == LAT, "R8 latency", k, LAT);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) chan_val[i] = 12'(i * 16'h0111 + 12'h0A5);
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1 && adc_sck == 1 && adc_mosi == 0, "R10 pins at reset", {adc_cs_n, adc_sck, adc_mosi}, 3'b110);
    chk(res_valid == 0 && {phase_a, phase_b, phase_c} == 36'd0, "R10 results at reset", {res_valid, phase_a, phase_b, phase_c}, 0);
    rst_n = 1'b1;
    model_on = 1;
    repeat (5) @(negedge clk);
    run_burst(12'h123, 12'hABC, 12'hFFF, 0, 0);
    repeat (10) @(negedge clk);
    run_burst(12'h000, 12'h800, 12'h7FF, 0, 0);
    repeat (7) @(negedge clk);
    run_burst(12'h555, 12'hAAA, 12'h001, 1, 0);
    repeat (30) @(negedge clk);
    run_burst(12'h3C3, 12'hC3C, 12'h0F0, 0, 0);
    run_burst(12'hFED, 12'h012, 12'h9A6, 0, 1);  // retrigger on the strobe cycle
    repeat (40) @(negedge clk);
    chk(frames_seen == 4 * bursts_m, "R9 frame count", frames_seen, 4 * bursts_m);
    chk(valids_seen == bursts_m && bursts_m == 5, "R9 strobe count", valids_seen, 5);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule